// File: doc/BRIEF.md
# Calibrated Pulse-Width Nibble Receiver

This block pulls bytes from a tape-style peripheral one pulse at a time. It asks for each pulse by driving its request line low. It then measures how long the peripheral holds the sense line low. Each width is mapped to one of sixteen levels, and two levels make one byte.

The mapping does not use fixed thresholds. The first two pulses after a recalibration are the shortest and the longest symbol the peripheral can send. From these the block learns a minimum width and a range. Each later width is placed inside that range by a four-step binary search. A 16-bit count taken at start sets how many bytes are read. A bad calibration pulse raises an error strobe and discards the learned values.

Top module: `pulse_nibble_rx`

## Requirements
- R1: After reset `req` is high, and `byte_valid`, `done` and `err` are low.
- R2: A `start` pulse in idle drives `req` low. In the first cycle after the clock edge that samples `sense` low for a pulse, `req` is high again.
- R3: A pulse width is the number of clock edges from the edge that samples `sense` falling to the edge that samples it rising. The edges are timestamped by a free-running 16-bit counter, and the difference is taken modulo 2^16. The measured value is this count divided by 4 (floor), saturated at 255.
- R4: While uncalibrated, the first width is stored as the minimum. The second width must be at least the minimum, and the difference must be at least 16. If so, the difference plus one becomes the range. Otherwise `err` pulses for one cycle, both values are cleared, `req` stays high and the block goes idle.
- R5: A data pulse whose width does not exceed the minimum decodes as nibble 0.
- R6: Any other data pulse gives v = width - min - 1 and is searched with lo = 0 and hi = range - 1. The search tests weights 8, 4, 2 and 1 in turn, with mid = floor((lo+hi)/2). If v < mid, then hi = mid - 1. Otherwise the weight is added to the nibble and lo = mid + 1.
- R7: The first nibble of a pair is bits 3:0 of `byte_data` and the second is bits 7:4; `byte_valid` pulses for one cycle with the byte.
- R8: A `byte_count` of N delivers N+1 bytes. `done` pulses in the same cycle as the last `byte_valid`. The block then goes idle with `req` high.
- R9: If `recal` is high at `start`, the calibration is cleared. If it is low, the calibration from the last transfer is kept and every pulse is treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted in idle) |
| recal | input | 1 | Discard calibration at start |
| byte_count | input | 16 | Bytes to read minus one |
| sense | input | 1 | Pulse line from the peripheral, low during a pulse |
| req | output | 1 | Request line, low asks for the next pulse |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Received byte |
| done | output | 1 | Transfer finished |
| err | output | 1 | Calibration failed |

## Verification
The nibble boundaries exist only after a calibration. They shift with every different minimum and range, so they cannot be reached by driving widths alone. The bench first calibrates to a known pair and then sweeps every width from below the minimum to past the top of the range, with a varying sub-multiple-of-four remainder. Each byte is compared with an arithmetic model of the search. Calibration failures are then forced on purpose. A following transfer without `recal` shows that the next two pulses are taken as calibration again.

// File: rtl/pulse_nibble_rx.sv
module pulse_nibble_rx #(
  parameter int TW = 16,
  parameter int WW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          recal,
  input  logic [CW-1:0] byte_count,
  input  logic          sense,
  output logic          req,
  output logic          byte_valid,
  output logic [7:0]    byte_data,
  output logic          done,
  output logic          err
);
  localparam logic [TW-1:0] WMAX = TW'((1 << WW) - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_HIGH, S_EVAL, S_SRCH, S_OUT} st_t;
  st_t st;

  logic          s_q, fall, rise;
  logic [TW-1:0] tmr, t0, diff, q;
  logic [WW-1:0] w, mn, v;
  logic [WW:0]   rng, lo, hi, mid, dw;
  logic [3:0]    nib, lo_nib;
  logic [1:0]    k;
  logic          half;
  logic [CW-1:0] cnt;

  assign fall = s_q & ~sense;
  assign rise = ~s_q & sense;
  assign diff = tmr - t0;
  assign q    = diff >> 2;
  assign mid  = WW'((({1'b0, hi} + {1'b0, lo}) >> 1));
  assign dw   = {1'b0, w} - {1'b0, mn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; s_q <= 1'b1; tmr <= '0; t0 <= '0; w <= '0;
      mn <= '0; rng <= '0; v <= '0; lo <= '0; hi <= '0; nib <= '0;
      lo_nib <= '0; k <= '0; half <= 1'b0; cnt <= '0; req <= 1'b1;
      byte_valid <= 1'b0; byte_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
      s_q <= sense;
      byte_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (recal) begin mn <= '0; rng <= '0; end
          cnt <= byte_count; half <= 1'b0; req <= 1'b0; st <= S_REQ;
        end
        S_REQ: if (fall) begin
          t0 <= tmr; req <= 1'b1; st <= S_HIGH;
        end
        S_HIGH: if (rise) begin
          w  <= (q > WMAX) ? WMAX[WW-1:0] : q[WW-1:0];
          st <= S_EVAL;
        end
        S_EVAL: begin
          if (mn == '0 && rng == '0) begin
            mn <= w; req <= 1'b0; st <= S_REQ;
          end else if (rng == '0) begin
            if (w < mn || dw < 16) begin
              err <= 1'b1; mn <= '0; rng <= '0; st <= S_IDLE;
            end else begin
              rng <= dw + 1'b1; req <= 1'b0; st <= S_REQ;
            end
          end else if (w <= mn) begin
            nib <= '0; st <= S_OUT;
          end else begin
            v <= w - mn - 1'b1; lo <= '0; hi <= rng - 1'b1;
            nib <= '0; k <= 2'd3; st <= S_SRCH;
          end
        end
        S_SRCH: begin
          if ({1'b0, v} < mid) hi <= mid - 1'b1;
          else begin nib[k] <= 1'b1; lo <= mid + 1'b1; end
          if (k == 2'd0) st <= S_OUT;
          else k <= k - 1'b1;
        end
        S_OUT: begin
          if (!half) begin
            lo_nib <= nib; half <= 1'b1; req <= 1'b0; st <= S_REQ;
          end else begin
            byte_data <= {nib, lo_nib}; byte_valid <= 1'b1; half <= 1'b0;
            if (cnt == '0) begin
              done <= 1'b1; st <= S_IDLE;
            end else begin
              cnt <= cnt - 1'b1; req <= 1'b0; st <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REQ && s_q && !sense) |=> req);
  p_done_with_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> byte_valid);
  p_strobes_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
  p_err_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (mn == '0 && rng == '0 && req));
  p_cal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SRCH) |=> ($stable(mn) && $stable(rng)));
  p_idle_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> req);
endmodule

// File: tb/pulse_nibble_rx_tb.sv
`timescale 1ns/1ps
module pulse_nibble_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, recal = 1'b0, sense = 1'b1;
  logic [15:0] byte_count = '0;
  logic req, byte_valid, done, err;
  logic [7:0] byte_data;
  int tests = 0, fails = 0;
  int nb = 0, ndone = 0, nerr = 0;
  logic [7:0] got [0:63];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pulse_nibble_rx u_dut (.clk(clk), .rst_n(rst_n), .start(start), .recal(recal),
    .byte_count(byte_count), .sense(sense), .req(req), .byte_valid(byte_valid),
    .byte_data(byte_data), .done(done), .err(err));

  always @(negedge clk) begin
    if (byte_valid && nb < 64) begin got[nb] = byte_data; nb++; end
    if (done) ndone++;
    if (err) nerr++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nibf(input int w, input int mn, input int rng);
    int v, lo, hi, mid, n;
    if (w <= mn) return 0;
    v = w - mn - 1; lo = 0; hi = rng - 1; n = 0;
    for (int b = 8; b >= 1; b = b / 2) begin
      mid = (lo + hi) / 2;
      if (v < mid) hi = mid - 1;
      else begin n += b; lo = mid + 1; end
    end
    return n;
  endfunction

  task automatic go(input bit rc, input int n);
    @(negedge clk); start = 1'b1; recal = rc; byte_count = 16'(n);
    @(negedge clk); start = 1'b0; recal = 1'b0;
  endtask

  task automatic pulse(input int len, input bit chk);
    while (req) @(negedge clk);
    sense = 1'b0;
    @(negedge clk);
    if (chk) check(req === 1'b1, "R2 req raised after fall", int'(req), 1);
    repeat (len - 1) @(negedge clk);
    sense = 1'b1;
    @(negedge clk);
  endtask

  function automatic int plen(input int w);
    return 4 * w + (w % 4);
  endfunction

  initial begin
    int mn, rng, e;
    repeat (3) @(negedge clk);
    check(req === 1'b1, "R1 req reset", int'(req), 1);
    check(byte_valid === 1'b0 && done === 1'b0 && err === 1'b0, "R1 strobes reset",
          int'({byte_valid, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 calibration, then sweep R5/R6/R7/R3
    go(1'b1, 49);
    check(req === 1'b0, "R2 req low after start", int'(req), 0);
    pulse(plen(20), 1'b1);
    pulse(plen(100), 1'b0);
    mn = 20; rng = 81;
    for (int w = 10; w < 110; w++) pulse(plen(w), 1'b0);
    repeat (20) @(negedge clk);
    check(nb == 50, "R8 byte count", nb, 50);
    check(ndone == 1, "R8 done once", ndone, 1);
    check(req === 1'b1, "R8 req idle", int'(req), 1);
    for (int i = 0; i < 50 && i < nb; i++) begin
      e = nibf(10 + 2 * i + 1, mn, rng) * 16 + nibf(10 + 2 * i, mn, rng);
      check(got[i] == 8'(e), "R6 R7 R5 swept byte", int'(got[i]), e);
    end

    // R9 calibration kept, R3 saturation
    nb = 0; ndone = 0;
    go(1'b0, 0);
    pulse(1100, 1'b0);
    pulse(plen(20), 1'b0);
    repeat (20) @(negedge clk);
    check(nb == 1, "R9 retained cal one byte", nb, 1);
    check(got[0] == 8'h0F, "R3 R9 saturated width byte", int'(got[0]), 15);
    check(ndone == 1, "R8 done single byte", ndone, 1);

    // R4 range too small
    nb = 0; nerr = 0; ndone = 0;
    go(1'b1, 3);
    pulse(plen(50), 1'b0);
    pulse(plen(60), 1'b0);
    repeat (10) @(negedge clk);
    check(nerr == 1, "R4 small range err", nerr, 1);
    check(req === 1'b1, "R4 idle after err", int'(req), 1);
    // after error the next two pulses calibrate again even without recal
    go(1'b0, 0);
    pulse(plen(30), 1'b0);
    pulse(plen(90), 1'b0);
    repeat (10) @(negedge clk);
    check(nb == 0 && nerr == 1, "R4 cleared cal recalibrates", nb, 0);
    pulse(plen(30), 1'b0);
    pulse(plen(90), 1'b0);
    repeat (20) @(negedge clk);
    e = nibf(90, 30, 61) * 16;
    check(nb == 1, "R4 byte after recal", nb, 1);
    check(got[0] == 8'(e), "R6 byte after recal", int'(got[0]), e);

    // R4 second width below minimum
    nerr = 0;
    go(1'b1, 0);
    pulse(plen(50), 1'b0);
    pulse(plen(40), 1'b0);
    repeat (10) @(negedge clk);
    check(nerr == 1, "R4 below min err", nerr, 1);
    check(req === 1'b1, "R4 req high after err", int'(req), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule